// File: doc/BRIEF.md
# Interrupt Throttle Scheduler

This block decides when interrupt messages leave the chip for a set of interrupt vectors. Each vector owns three programmable throttle intervals. A requester names a vector and a throttle slot. The block turns the chosen interval into a minimum delay and keeps one pending countdown per vector. When a countdown runs out, the block offers that vector on a valid/ready issue port.

A new request for a vector that is already pending can only bring its deadline forward. It never pushes the deadline back. Slot value 3 skips throttling altogether.

A mode input chooses between two kinds of delivery. In per-vector delivery every vector issues on its own number. In single-message delivery only vector 0 may issue. Any other vector that expires in that mode is dropped and raises a sticky error flag. A synchronous soft reset returns the whole block to its power-up state.

Time runs on a prescaler that gives one tick every `TICK_DIV` clocks. With the default setting that is one microsecond at 200 MHz. One interval unit is two ticks.

Top module: `irq_throttle_sched`

## Requirements
- R1: The prescaler produces one tick every `TICK_DIV` clocks, and one interval unit equals 2 ticks. For a delay of D ticks with D > 0, `issue_valid` for the vector appears between (D-1)*TICK_DIV+1 and D*TICK_DIV clock edges after the request edge.
- R2: Each vector has three interval registers, written through `cfg_we`/`cfg_vec`/`cfg_sel`/`cfg_data`. The request field `req_sel` values 0, 1 and 2 select the vector's own register of the same number. The delay is that register's value times 2 ticks.
- R3: `req_sel` = 3 means no throttling. The vector becomes issuable right after the request edge, so `issue_valid` is seen one edge after the request.
- R4: A request to an idle vector arms it with the computed delay. The vector is issued once when its delay runs out.
- R5: A request to an armed vector whose remaining delay is no larger than the new delay has no effect. The issue time stays that of the first request.
- R6: A request to an armed vector whose remaining delay is larger than the new delay re-arms it with the new, shorter delay.
- R7: `issue_valid` and `issue_vec` hold steady while `issue_ready` is low. An accepted issue disarms the vector, so one arming gives exactly one issue.
- R8: When several vectors are waiting to issue, the lowest-numbered one is offered first.
- R9: With `single_msg` = 1, only vector 0 issues, with `issue_vec` = 0. A nonzero vector that expires is discarded without an issue and sets `err_flag`. `err_flag` stays set until reset.
- R10: `soft_rst` disarms all vectors and clears every interval register and `err_flag`. After it, a request with `req_sel` 0 issues at once, because the interval is now 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| single_msg | input | 1 | 1 = single-message delivery, 0 = per-vector delivery |
| cfg_we | input | 1 | Interval register write strobe |
| cfg_vec | input | $clog2(NUM_VEC) | Vector whose interval is written |
| cfg_sel | input | 2 | Interval slot 0..2; value 3 writes nothing |
| cfg_data | input | IVAL_W | Interval value, in units of 2 ticks |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | $clog2(NUM_VEC) | Requested vector |
| req_sel | input | 2 | Throttle slot 0..2, or 3 for no throttling |
| issue_valid | output | 1 | An interrupt is offered |
| issue_vec | output | $clog2(NUM_VEC) | Vector being offered |
| issue_ready | input | 1 | The consumer takes the offered interrupt |
| err_flag | output | 1 | Sticky: a nonzero vector expired in single-message mode |

## Verification
The bench measures the latency from a request to its issue and checks it against the tick window for each interval slot. Swapped slots, or a missing factor of two, show up as an issue outside the window.

It repeats a request with a longer delay and checks that the issue still lands in the first request's window. A design that always reloads the countdown would issue late. It also follows a long delay with a short one, where a design that ignores armed vectors would issue far too late.

With the issue port stalled, three vectors queue up. The bench checks that the held vector stays put and that the rest drain in ascending order. A design that re-arbitrates while stalled, or picks the highest number first, would change `issue_vec`.

Single-message mode and soft reset are checked through the error flag. After a reset, a pending vector must stay silent and a request with a cleared interval must issue at once.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

  typedef enum logic [1:0] {
    THR_SLOT0 = 2'd0,
    THR_SLOT1 = 2'd1,
    THR_SLOT2 = 2'd2,
    THR_NONE  = 2'd3
  } thr_sel_e;

  // Delay in prescaler ticks: each interval unit is two ticks, slot 3 bypasses.
  function automatic logic [31:0] thr_delay_ticks(input logic [31:0] ival,
                                                  input logic [1:0]  sel);
    if (sel == THR_NONE) return 32'd0;
    return ival << 1;
  endfunction

endpackage

// File: rtl/irq_thr_prescaler.sv
module irq_thr_prescaler #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      assign tick = (cnt_q == CW'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (soft_rst) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
      end

      // R1: ticks are separated by at least one idle clock
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !soft_rst |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/irq_thr_vec_timer.sv
module irq_thr_vec_timer
  import irq_thr_pkg::*;
#(
  parameter int IVAL_W = 8,
  localparam int RW    = IVAL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic              cfg_hit,
  input  logic [1:0]        cfg_sel,
  input  logic [IVAL_W-1:0] cfg_data,
  input  logic              req_hit,
  input  logic [1:0]        req_sel,
  input  logic              clear,
  output logic              due
);
  logic [IVAL_W-1:0] ival_q [3];
  logic              armed_q;
  logic [RW-1:0]     rem_q;
  logic [IVAL_W-1:0] sel_ival;
  logic [RW-1:0]     new_d;
  logic              armed_eff;
  logic              load;

  always_comb begin
    case (req_sel)
      THR_SLOT0: sel_ival = ival_q[0];
      THR_SLOT1: sel_ival = ival_q[1];
      THR_SLOT2: sel_ival = ival_q[2];
      default:   sel_ival = '0;
    endcase
  end

  assign new_d     = RW'(thr_delay_ticks(32'(sel_ival), req_sel));
  assign armed_eff = armed_q & ~clear;
  // only an earlier deadline may replace a pending one
  assign load      = req_hit & (~armed_eff | (new_d < rem_q));
  assign due       = armed_q & (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      for (int i = 0; i < 3; i++) ival_q[i] <= '0;
      armed_q <= 1'b0;
      rem_q   <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (cfg_hit && cfg_sel == 2'(i)) ival_q[i] <= cfg_data;
      if (load) begin
        armed_q <= 1'b1;
        rem_q   <= new_d;
      end else if (clear) begin
        armed_q <= 1'b0;
        rem_q   <= '0;
      end else if (armed_q && tick && rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  // R5/R6: a pending deadline only moves earlier
  a_r5_never_later: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !clear && !soft_rst |=> armed_q && rem_q <= $past(rem_q));
  // R3: bypass slot makes the vector due immediately
  a_r3_bypass_due: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit && req_sel == THR_NONE && !soft_rst |=> due);
endmodule

// File: rtl/irq_thr_pick.sv
module irq_thr_pick #(
  parameter int N   = 4,
  localparam int VW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [VW-1:0] idx
);
  assign any = |elig;
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) idx = VW'(i);
  end
endmodule

// File: rtl/irq_throttle_sched.sv
module irq_throttle_sched #(
  parameter int NUM_VEC  = 4,
  parameter int IVAL_W   = 8,
  parameter int TICK_DIV = 200,
  localparam int VW      = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              single_msg,
  input  logic              cfg_we,
  input  logic [VW-1:0]     cfg_vec,
  input  logic [1:0]        cfg_sel,
  input  logic [IVAL_W-1:0] cfg_data,
  input  logic              req_valid,
  input  logic [VW-1:0]     req_vec,
  input  logic [1:0]        req_sel,
  output logic              issue_valid,
  output logic [VW-1:0]     issue_vec,
  input  logic              issue_ready,
  output logic              err_flag
);
  logic               tick;
  logic [NUM_VEC-1:0] due, elig, drop, clr;
  logic               pick_any;
  logic [VW-1:0]      pick_idx;
  logic               hold_q;
  logic [VW-1:0]      hold_vec_q;
  logic               err_q;
  logic               issue_fire;

  irq_thr_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick)
  );

  assign issue_fire = issue_valid & issue_ready;

  generate
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      localparam logic [VW-1:0] VID = VW'(v);
      assign elig[v] = due[v] & (!single_msg || v == 0);
      assign drop[v] = due[v] & single_msg & (v != 0) &
                       ~(hold_q && hold_vec_q == VID);
      assign clr[v]  = (issue_fire && issue_vec == VID) | drop[v];

      irq_thr_vec_timer #(.IVAL_W(IVAL_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick),
        .cfg_hit(cfg_we && cfg_vec == VID), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data),
        .req_hit(req_valid && req_vec == VID), .req_sel(req_sel),
        .clear(clr[v]), .due(due[v])
      );
    end
  endgenerate

  irq_thr_pick #(.N(NUM_VEC)) u_pick (
    .elig(elig), .any(pick_any), .idx(pick_idx)
  );

  assign issue_valid = hold_q | pick_any;
  assign issue_vec   = hold_q ? hold_vec_q : pick_idx;
  assign err_flag    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      hold_q     <= 1'b0;
      hold_vec_q <= '0;
      err_q      <= 1'b0;
    end else begin
      hold_q     <= issue_valid & ~issue_ready;
      hold_vec_q <= issue_vec;
      err_q      <= err_q | (|drop);
    end
  end

  // R7: a stalled offer stays put
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready && !soft_rst |=> issue_valid && $stable(issue_vec));
  // R9: a fresh offer in single-message mode is vector 0
  a_r9_single_vec0: assert property (@(posedge clk) disable iff (!rst_n)
    single_msg && $rose(issue_valid) |-> issue_vec == '0);
  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !soft_rst |=> err_flag);
  // R10: soft reset clears the offer and the flag
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !hold_q && !err_flag);
endmodule

// File: tb/tb_irq_throttle_sched.sv
module tb_irq_throttle_sched;
  localparam int NV  = 4;
  localparam int IW  = 8;
  localparam int DIV = 200;
  localparam int VW  = $clog2(NV);

  logic clk = 0, rst_n = 0, soft_rst = 0, single_msg = 0;
  logic cfg_we = 0; logic [VW-1:0] cfg_vec = 0; logic [1:0] cfg_sel = 0;
  logic [IW-1:0] cfg_data = 0;
  logic req_valid = 0; logic [VW-1:0] req_vec = 0; logic [1:0] req_sel = 0;
  logic issue_valid, issue_ready = 1, err_flag;
  logic [VW-1:0] issue_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_throttle_sched #(.NUM_VEC(NV), .IVAL_W(IW), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .single_msg(single_msg),
    .cfg_we(cfg_we), .cfg_vec(cfg_vec), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_vec(req_vec), .req_sel(req_sel),
    .issue_valid(issue_valid), .issue_vec(issue_vec),
    .issue_ready(issue_ready), .err_flag(err_flag));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg(input int v, input int s, input int d);
    @(negedge clk); cfg_we = 1; cfg_vec = VW'(v); cfg_sel = 2'(s); cfg_data = IW'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  // drive one request; returns at the negedge just after the request edge
  task automatic send(input int v, input int s);
    @(negedge clk); req_valid = 1; req_vec = VW'(v); req_sel = 2'(s);
    @(negedge clk); req_valid = 0;
  endtask

  // edges since the request edge until vector v is offered (we are at the first negedge)
  task automatic wait_issue(input int v, input int limit, output int c);
    c = 1;
    while (!(issue_valid && issue_vec == VW'(v)) && c < limit) begin
      @(negedge clk); c++;
    end
  endtask

  task automatic check_window(input string rq, input int c, input int d);
    int lo, hi;
    lo = (d == 0) ? 1 : (d - 1) * DIV + 1;
    hi = (d == 0) ? 1 : d * DIV;
    chk(c >= lo && c <= hi, rq, c, hi);
  endtask

  task automatic t_reset;
    chk(issue_valid == 0, "R10 reset issue_valid", issue_valid, 0);
    chk(err_flag == 0, "R10 reset err_flag", err_flag, 0);
  endtask

  task automatic t_slots;  // R1 R2 R4
    int c;
    cfg(1, 0, 1); cfg(1, 1, 3); cfg(1, 2, 5);
    send(1, 0); wait_issue(1, 3 * DIV, c); check_window("R2 slot0 latency", c, 2);
    @(negedge clk); chk(issue_valid == 0, "R4 single issue per arming", issue_valid, 0);
    send(1, 1); wait_issue(1, 7 * DIV, c); check_window("R1 slot1 latency", c, 6);
    send(1, 2); wait_issue(1, 11 * DIV, c); check_window("R2 slot2 latency", c, 10);
    @(negedge clk);
  endtask

  task automatic t_bypass;  // R3
    int c;
    send(2, 3); wait_issue(2, 5, c); check_window("R3 bypass latency", c, 0);
    @(negedge clk);
  endtask

  task automatic t_no_push;  // R5
    int c;
    cfg(1, 0, 5); cfg(1, 1, 20);
    send(1, 0);
    c = 1;
    while (c < 2 * DIV) begin @(negedge clk); c++; end
    req_valid = 1; req_vec = 1; req_sel = 1;
    @(negedge clk); c++; req_valid = 0;
    send(1, 0); c += 2;  // equal-size request also ignored
    while (!(issue_valid && issue_vec == 1) && c < 45 * DIV) begin @(negedge clk); c++; end
    check_window("R5 later request ignored", c, 10);
    @(negedge clk);
  endtask

  task automatic t_pull_in;  // R6
    int c;
    cfg(2, 1, 20); cfg(2, 0, 2);
    send(2, 1); send(2, 0);
    wait_issue(2, 41 * DIV, c); check_window("R6 re-armed earlier", c, 4);
    @(negedge clk);
  endtask

  task automatic t_order;  // R7 R8
    issue_ready = 0;
    send(0, 3); send(3, 3); send(1, 3);
    repeat (3) @(negedge clk);
    chk(issue_valid && issue_vec == 0, "R7 held offer", issue_vec, 0);
    issue_ready = 1;
    @(negedge clk); chk(issue_valid && issue_vec == 1, "R8 lowest next", issue_vec, 1);
    @(negedge clk); chk(issue_valid && issue_vec == 3, "R8 then highest", issue_vec, 3);
    @(negedge clk); chk(issue_valid == 0, "R7 drained", issue_valid, 0);
  endtask

  task automatic t_single;  // R9
    int c;
    single_msg = 1;
    send(2, 3); repeat (2) @(negedge clk);
    chk(issue_valid == 0, "R9 nonzero dropped", issue_valid, 0);
    chk(err_flag == 1, "R9 err set", err_flag, 1);
    send(0, 3); wait_issue(0, 5, c); check_window("R9 vector0 issues", c, 0);
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk(err_flag == 1, "R9 err sticky", err_flag, 1);
    single_msg = 0;
  endtask

  task automatic t_soft;  // R10
    int c;
    cfg(1, 0, 50); cfg(3, 1, 2); send(3, 1);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk(err_flag == 0, "R10 err cleared", err_flag, 0);
    send(1, 0); wait_issue(1, 5, c); check_window("R10 interval cleared", c, 0);
    @(negedge clk);
    c = 0;
    repeat (6 * DIV) begin @(negedge clk); if (issue_valid) c++; end
    chk(c == 0, "R10 pending disarmed", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset; t_slots; t_bypass; t_no_push; t_pull_in; t_order; t_single; t_soft;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule